// File: doc/BRIEF.md
# Paging Receiver Power-Save Sequencer

This block drives the three power-control lines that switch a paging receiver on and off around the parts of each batch that the pager must hear. It runs from the 76.8 kHz system clock: one `clk` cycle is one system-clock period. From that clock it derives the bit period for 512, 1200 or 2400 bps, the codeword period, and the seventeen codeword slots of a batch. Slot 0 carries the sync codeword. Frame f occupies slots 2f+1 and 2f+2. The receive window is slot 0 plus the two slots of every frame enabled in `frame_sel`.

Three outputs are raised around each window start, each with its own lead time. `pll_setup_en` rises first so that the synthesizer can settle. `rf_pwr_en` then powers the RF section. `dc_adj_req` asks the RF stage for a DC-level adjustment, either during the lead-in or at the start of the window. Lead times are given in setup steps. A step is a fixed number of system clocks chosen per bit rate, so even the longest lead fits inside one codeword.

While the block is acquiring, it holds every output high until the bit-recovery logic reports the sync codeword on `sync_found`. From then on it powers the receiver only for the windows. If the sync codeword is missing in `miss_limit` consecutive batches, the block falls back to continuous reception. All configuration inputs are plain level controls. They are expected to stay stable while the block is tracking.

Top module: `rx_power_sequencer`

## Requirements
- R1: After reset, and for as long as the block is acquiring, `rf_pwr_en`, `pll_setup_en` and `dc_adj_req` are all 1. A `sync_found` pulse sampled while acquiring starts tracking on the next cycle, with the timer at the first clock of slot 1.
- R2: Rate codes are 0 for 512 bps (150 clocks per bit), 1 for 1200 bps (64 clocks per bit), 2 for 2400 bps (32 clocks per bit), and 3, which behaves as 2400 bps. A codeword lasts 32 bits and a batch has 17 slots. While tracking, `rf_pwr_en` and `pll_setup_en` are 1 in every window slot (slot 0, and slots 2f+1 and 2f+2 when `frame_sel[f]` is 1) and 0 outside the windows and their leads.
- R3: While tracking, `rf_pwr_en` rises exactly `rf_lead_steps` × P clocks before the first clock of a window slot that follows a non-window slot. P is 64, 32 and 16 clocks for rate codes 0, 1 and 2/3.
- R4: Step counts of 0 act as 1, and step counts of 62 or 63 act as 61.
- R5: `pll_setup_en` rises max(`pll_lead_steps`, `rf_lead_steps`) × P clocks before a window start, so it is never 0 while `rf_pwr_en` is 1.
- R6: With `adj_during_rx` = 0, `dc_adj_req` is 1 exactly during the lead-in part of `rf_pwr_en` (before a window start) and 0 inside windows.
- R7: With `adj_during_rx` = 1, `dc_adj_req` is 1 for the first 8 bit periods of a window slot whose preceding slot is outside the window, and 0 otherwise.
- R8: While tracking, a `sync_found` pulse outside slot 0 has no effect on the outputs or on timing.
- R9: A batch whose slot 0 ends with no `sync_found` during that slot counts as a miss, and a found sync clears the count. When the count reaches `miss_limit` (0 acts as 1), the block is acquiring again on the cycle after that slot 0 ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 76.8 kHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 2 | Bit-rate code (0: 512, 1: 1200, 2/3: 2400 bps) |
| frame_sel | input | 8 | One enable bit per frame to monitor |
| rf_lead_steps | input | 6 | RF power lead time in setup steps |
| pll_lead_steps | input | 6 | Synthesizer setup lead time in setup steps |
| adj_during_rx | input | 1 | 0: DC adjust in lead-in, 1: DC adjust at window start |
| miss_limit | input | 3 | Consecutive missed syncs before re-acquisition |
| sync_found | input | 1 | One-cycle pulse when the sync codeword is detected |
| rf_pwr_en | output | 1 | RF section power enable |
| pll_setup_en | output | 1 | Synthesizer setup enable |
| dc_adj_req | output | 1 | RF DC-level adjustment request |

## Verification
The assertions take for granted that `rate_sel`, `frame_sel` and the step counts do not change while the block is tracking. They also take `sync_found` to be a single-cycle pulse. A mid-window rate change would break the lead and countdown relations they check. The stimulus sets every configuration input before reset and holds it for the whole run. It raises `sync_found` for exactly one cycle, at times chosen relative to the slot boundaries: while acquiring, in a data slot, and inside slot 0.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

  localparam int BITS_PER_CW   = 32;
  localparam int CW_PER_FRAME  = 2;
  localparam int MAX_BIT_CLKS  = 150;

  typedef enum logic [1:0] {
    RATE_512  = 2'd0,
    RATE_1200 = 2'd1,
    RATE_2400 = 2'd2,
    RATE_RSVD = 2'd3
  } rate_e;

  typedef enum logic {
    LK_ACQ   = 1'b0,
    LK_TRACK = 1'b1
  } lock_e;

  // System clocks per bit at 76.8 kHz
  function automatic int unsigned bit_clks(rate_e r);
    case (r)
      RATE_512:  return 150;
      RATE_1200: return 64;
      default:   return 32;
    endcase
  endfunction

  // System clocks per setup step; 61 steps stay under one codeword
  function automatic int unsigned step_clks(rate_e r);
    case (r)
      RATE_512:  return 64;
      RATE_1200: return 32;
      default:   return 16;
    endcase
  endfunction

endpackage

// File: rtl/rxps_clamp.sv
module rxps_clamp #(
  parameter int W   = 6,
  parameter int MIN = 1,
  parameter int MAX = 61
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] legal
);
  localparam logic [W-1:0] LO = W'(MIN);
  localparam logic [W-1:0] HI = W'(MAX);

  always_comb begin
    if (raw < LO)      legal = LO;
    else if (raw > HI) legal = HI;
    else               legal = raw;
  end
endmodule

// File: rtl/rxps_slot_timer.sv
module rxps_slot_timer #(
  parameter int SLOTS  = 17,
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [CNT_W-1:0]  cw_clks,
  output logic [SLOT_W-1:0] slot,
  output logic [CNT_W-1:0]  rem,
  output logic              slot_end
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  assign slot_end = run & (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      rem  <= '0;
    end else if (load) begin
      slot <= SLOT_W'(1);
      rem  <= cw_clks - CNT_W'(1);
    end else if (run) begin
      if (rem == '0) begin
        rem  <= cw_clks - CNT_W'(1);
        slot <= (slot == LAST_SLOT) ? '0 : slot + SLOT_W'(1);
      end else begin
        rem <= rem - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rxps_window_map.sv
module rxps_window_map #(
  parameter int FRAMES = 8,
  parameter int SLOTS  = 17,
  parameter int SLOT_W = 5
) (
  input  logic [FRAMES-1:0] frame_sel,
  input  logic [SLOT_W-1:0] slot,
  output logic              win_cur,
  output logic              win_next,
  output logic              win_prev
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOTS-1:0]  win;
  logic [SLOT_W-1:0] nxt_idx;
  logic [SLOT_W-1:0] prv_idx;

  assign win[0] = 1'b1;  // sync slot is always heard

  for (genvar f = 0; f < FRAMES; f++) begin : g_frame
    assign win[2*f+1] = frame_sel[f];
    assign win[2*f+2] = frame_sel[f];
  end

  always_comb begin
    nxt_idx  = (slot == LAST_SLOT) ? '0 : slot + SLOT_W'(1);
    prv_idx  = (slot == '0) ? LAST_SLOT : slot - SLOT_W'(1);
    win_cur  = win[slot];
    win_next = win[nxt_idx];
    win_prev = win[prv_idx];
  end
endmodule

// File: rtl/rxps_lock_fsm.sv
module rxps_lock_fsm import rxps_pkg::*; #(
  parameter int MISS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_found,
  input  logic              in_sync_slot,
  input  logic              slot_end,
  input  logic [MISS_W-1:0] miss_limit,
  output logic              tracking,
  output logic              load
);
  lock_e             state;
  logic              seen;
  logic [MISS_W-1:0] misses;
  logic [MISS_W:0]   misses_inc;

  assign tracking   = (state == LK_TRACK);
  assign load       = (state == LK_ACQ) & sync_found;
  assign misses_inc = {1'b0, misses} + (MISS_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LK_ACQ;
      seen   <= 1'b0;
      misses <= '0;
    end else begin
      case (state)
        LK_ACQ: begin
          if (sync_found) begin
            state  <= LK_TRACK;
            seen   <= 1'b0;
            misses <= '0;
          end
        end
        default: begin
          if (in_sync_slot && sync_found) seen <= 1'b1;
          if (in_sync_slot && slot_end) begin
            seen <= 1'b0;
            if (seen || sync_found) begin
              misses <= '0;
            end else if (misses_inc >= {1'b0, miss_limit}) begin
              state  <= LK_ACQ;
              misses <= '0;
            end else begin
              misses <= misses_inc[MISS_W-1:0];
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_power_sequencer.sv
module rx_power_sequencer import rxps_pkg::*; #(
  parameter int FRAMES   = 8,
  parameter int LEAD_W   = 6,
  parameter int LEAD_MIN = 1,
  parameter int LEAD_MAX = 61,
  parameter int MISS_W   = 3,
  parameter int ADJ_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic [FRAMES-1:0] frame_sel,
  input  logic [LEAD_W-1:0] rf_lead_steps,
  input  logic [LEAD_W-1:0] pll_lead_steps,
  input  logic              adj_during_rx,
  input  logic [MISS_W-1:0] miss_limit,
  input  logic              sync_found,
  output logic              rf_pwr_en,
  output logic              pll_setup_en,
  output logic              dc_adj_req
);
  localparam int SLOTS  = 1 + FRAMES * CW_PER_FRAME;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(MAX_BIT_CLKS * BITS_PER_CW + 1);

  rate_e             rate;
  logic [CNT_W-1:0]  bit_clk, step_clk, cw_clks;
  logic [CNT_W-1:0]  rf_lead_clks, pll_lead_clks, adj_clks, elapsed;
  logic [LEAD_W-1:0] rf_steps, pll_steps, pll_steps_eff;
  logic [MISS_W-1:0] miss_lim_eff;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  rem;
  logic              slot_end, tracking, load;
  logic              win_cur, win_next, win_prev;
  logic              rf_lead_on, pll_lead_on, adj_start_on;

  rxps_clamp #(.W(LEAD_W), .MIN(LEAD_MIN), .MAX(LEAD_MAX)) u_rf_clamp (
    .raw(rf_lead_steps), .legal(rf_steps));
  rxps_clamp #(.W(LEAD_W), .MIN(LEAD_MIN), .MAX(LEAD_MAX)) u_pll_clamp (
    .raw(pll_lead_steps), .legal(pll_steps));
  rxps_clamp #(.W(MISS_W), .MIN(1), .MAX((1 << MISS_W) - 1)) u_miss_clamp (
    .raw(miss_limit), .legal(miss_lim_eff));

  always_comb begin
    rate          = rate_e'(rate_sel);
    bit_clk       = CNT_W'(bit_clks(rate));
    step_clk      = CNT_W'(step_clks(rate));
    cw_clks       = CNT_W'(bit_clks(rate) * BITS_PER_CW);
    pll_steps_eff = (pll_steps > rf_steps) ? pll_steps : rf_steps;
    rf_lead_clks  = CNT_W'(rf_steps) * step_clk;
    pll_lead_clks = CNT_W'(pll_steps_eff) * step_clk;
    adj_clks      = CNT_W'(ADJ_BITS) * bit_clk;
    elapsed       = cw_clks - CNT_W'(1) - rem;
  end

  rxps_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tracking), .load(load),
    .cw_clks(cw_clks), .slot(slot), .rem(rem), .slot_end(slot_end));

  rxps_window_map #(.FRAMES(FRAMES), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_map (
    .frame_sel(frame_sel), .slot(slot),
    .win_cur(win_cur), .win_next(win_next), .win_prev(win_prev));

  rxps_lock_fsm #(.MISS_W(MISS_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .sync_found(sync_found),
    .in_sync_slot(slot == '0), .slot_end(slot_end),
    .miss_limit(miss_lim_eff), .tracking(tracking), .load(load));

  // Outputs decode registered timer and lock state only
  always_comb begin
    rf_lead_on   = ~win_cur & win_next & (rem < rf_lead_clks);
    pll_lead_on  = ~win_cur & win_next & (rem < pll_lead_clks);
    adj_start_on = win_cur & ~win_prev & (elapsed < adj_clks);
    rf_pwr_en    = ~tracking | win_cur | rf_lead_on;
    pll_setup_en = ~tracking | win_cur | pll_lead_on;
    dc_adj_req   = ~tracking | (adj_during_rx ? adj_start_on : rf_lead_on);
  end
endmodule

// File: rtl/rxps_checker.sv
module rxps_checker #(
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 13,
  parameter int SLOTS  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tracking,
  input logic [SLOT_W-1:0] slot,
  input logic [CNT_W-1:0]  rem,
  input logic              sync_found,
  input logic              adj_during_rx,
  input logic              rf_pwr_en,
  input logic              pll_setup_en,
  input logic              dc_adj_req
);
  assert_acq_all_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tracking |-> (rf_pwr_en && pll_setup_en && dc_adj_req));

  assert_track_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tracking) |-> ($past(sync_found) && slot == SLOT_W'(1)));

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot < SLOT_W'(SLOTS));

  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && rem != '0) |=> (rem == $past(rem) - CNT_W'(1)));

  assert_pll_not_after_rf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_pwr_en |-> pll_setup_en);

  assert_adj_in_leadin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_during_rx && dc_adj_req) |-> (rf_pwr_en && pll_setup_en));

  assert_adj_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_during_rx && dc_adj_req) |-> rf_pwr_en);

  assert_stray_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && sync_found && slot != '0) |=> tracking);

  assert_drop_at_sync_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tracking) |-> ($past(slot) == '0 && $past(rem) == '0));
endmodule

bind rx_power_sequencer rxps_checker #(
  .SLOT_W(SLOT_W), .CNT_W(CNT_W), .SLOTS(SLOTS)
) u_rxps_checker (
  .clk(clk), .rst_n(rst_n), .tracking(tracking), .slot(slot), .rem(rem),
  .sync_found(sync_found), .adj_during_rx(adj_during_rx),
  .rf_pwr_en(rf_pwr_en), .pll_setup_en(pll_setup_en), .dc_adj_req(dc_adj_req)
);

// File: tb/test_rx_power_sequencer.sv
module test_rx_power_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd2;
  logic [7:0] frame_sel = 8'h02;
  logic [5:0] rf_lead_steps = 6'd10;
  logic [5:0] pll_lead_steps = 6'd20;
  logic       adj_during_rx = 1'b0;
  logic [2:0] miss_limit = 3'd7;
  logic       sync_found = 1'b0;
  logic       rf_pwr_en, pll_setup_en, dc_adj_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rx_power_sequencer i_rx_power_sequencer (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .frame_sel(frame_sel),
    .rf_lead_steps(rf_lead_steps), .pll_lead_steps(pll_lead_steps),
    .adj_during_rx(adj_during_rx), .miss_limit(miss_limit),
    .sync_found(sync_found), .rf_pwr_en(rf_pwr_en),
    .pll_setup_en(pll_setup_en), .dc_adj_req(dc_adj_req));

  // n = clock edges after the edge that sampled sync_found; exp = {rf, pll, adj}
  typedef struct packed {
    logic [1:0]  rate;
    logic [7:0]  mask;
    logic [5:0]  rf;
    logic [5:0]  pll;
    logic        mode;
    logic [15:0] n;
    logic [2:0]  exp;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b0, 16'd1888,  3'b111, 4'd3}, // R3 rf lead edge
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b0, 16'd1887,  3'b010, 4'd5}, // R5 pll only
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b0, 16'd1728,  3'b010, 4'd5}, // R5 pll edge
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b0, 16'd1727,  3'b000, 4'd5}, // R5 before pll
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b0, 16'd2048,  3'b110, 4'd2}, // R2 window start
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b1, 16'd2048,  3'b111, 4'd7}, // R7 adj first clk
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b1, 16'd2303,  3'b111, 4'd7}, // R7 adj last clk
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b1, 16'd2304,  3'b110, 4'd7}, // R7 adj over
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b1, 16'd3072,  3'b110, 4'd7}, // R7 second slot
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b0, 16'd4096,  3'b000, 4'd2}, // R2 after window
    '{2'd2, 8'h02, 6'd10, 6'd20, 1'b0, 16'd16383, 3'b111, 4'd6}, // R6 lead to sync
    '{2'd2, 8'h02, 6'd0,  6'd0,  1'b0, 16'd2032,  3'b111, 4'd4}, // R4 zero -> 1
    '{2'd2, 8'h02, 6'd0,  6'd0,  1'b0, 16'd2031,  3'b000, 4'd4}, // R4
    '{2'd2, 8'h02, 6'd63, 6'd0,  1'b0, 16'd1072,  3'b111, 4'd4}, // R4 63 -> 61
    '{2'd2, 8'h02, 6'd63, 6'd0,  1'b0, 16'd1071,  3'b000, 4'd4}, // R4
    '{2'd2, 8'h02, 6'd30, 6'd5,  1'b0, 16'd1568,  3'b111, 4'd5}, // R5 pll raised
    '{2'd2, 8'h02, 6'd30, 6'd5,  1'b0, 16'd1567,  3'b000, 4'd5}, // R5
    '{2'd1, 8'h02, 6'd10, 6'd20, 1'b0, 16'd3776,  3'b111, 4'd3}, // R3 1200 bps
    '{2'd1, 8'h02, 6'd10, 6'd20, 1'b0, 16'd3775,  3'b010, 4'd3}, // R3 1200 bps
    '{2'd0, 8'h02, 6'd10, 6'd20, 1'b0, 16'd8959,  3'b010, 4'd3}, // R3 512 bps
    '{2'd2, 8'h06, 6'd10, 6'd20, 1'b0, 16'd4095,  3'b110, 4'd6}, // R6 merged window
    '{2'd2, 8'h06, 6'd10, 6'd20, 1'b1, 16'd4096,  3'b110, 4'd7}, // R7 merged window
    '{2'd2, 8'h01, 6'd10, 6'd20, 1'b1, 16'd0,     3'b110, 4'd7}, // R7 after sync slot
    '{2'd3, 8'h02, 6'd10, 6'd20, 1'b0, 16'd1887,  3'b010, 4'd2}  // R2 code 3 = 2400
  };

  function automatic string req_name(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic adv(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {rf_pwr_en, pll_setup_en, dc_adj_req};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b (rf,pll,adj)", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sync_found = 1'b0;
    adv(3);
    rst_n = 1'b1;
    adv(1);
  endtask

  task automatic go_track();
    sync_found = 1'b1;
    adv(1);
    sync_found = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_found = 1'b1;
    adv(1);
    sync_found = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    // R1: reset state and acquisition hold
    @(negedge clk);
    check("R1", 3'b111);
    do_reset();
    check("R1", 3'b111);
    adv(50);
    check("R1", 3'b111);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      rate_sel       = VECS[i].rate;
      frame_sel      = VECS[i].mask;
      rf_lead_steps  = VECS[i].rf;
      pll_lead_steps = VECS[i].pll;
      adj_during_rx  = VECS[i].mode;
      miss_limit     = 3'd7;
      do_reset();
      go_track();
      adv(int'(VECS[i].n));
      check(req_name(VECS[i].tag), VECS[i].exp);
    end

    // R8 and R9: stray sync ignored, two misses drop back to acquisition
    rate_sel = 2'd2; frame_sel = 8'h01; rf_lead_steps = 6'd10;
    pll_lead_steps = 6'd20; adj_during_rx = 1'b0; miss_limit = 3'd2;
    do_reset();
    go_track();
    adv(2999);
    pulse_sync();            // now n = 3000, in slot 3
    adv(1);
    check("R8", 3'b000);
    adv(34815 - 3001);
    check("R9", 3'b110);     // slot 0 last clock, still tracking
    adv(1);
    check("R9", 3'b111);     // acquiring again

    // R9: limit 0 acts as 1
    miss_limit = 3'd0;
    do_reset();
    go_track();
    adv(17407);
    check("R9", 3'b110);
    adv(1);
    check("R9", 3'b111);

    // R9: sync seen in slot 0 keeps tracking with limit 1
    miss_limit = 3'd1;
    do_reset();
    go_track();
    adv(16484);
    pulse_sync();            // n = 16485, in slot 0
    adv(19456 - 16485);
    check("R9", 3'b000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule